// File: doc/BRIEF.md
# Pipelined Bit-Masked Write RAM

This block is a simple dual-port memory whose write port takes a mask with one bit per data bit. Only the bits whose mask bit is 1 take the new data; the others keep what was stored. The storage array underneath only accepts whole-word writes and reads synchronously. Each masked write is therefore done as a read-modify-write spread over a short pipeline: read the stored word, merge the new bits under the mask, then write the merged word back.

A masked write can be accepted on every clock cycle with no stalls. A merged word reaches the array on the second clock edge after the write is accepted. Until then it is held in pipeline registers, and a later write to the same address takes its old word from those registers instead of the stale array read.

A separate read port returns registered data. It has old-data semantics: a write still in flight is not visible to it. Data width and depth are parameters.

Top module: `bitmask_rmw_ram`

## Requirements
- R1: After a write has committed, each stored bit `k` equals `wr_data[k]` where `wr_mask[k]` is 1 and the previously stored bit where `wr_mask[k]` is 0.
- R2: A clock edge with `wr_en` low leaves every stored word unchanged, whatever `wr_addr`, `wr_data` and `wr_mask` carry.
- R3: `rd_data` changes only on a clock edge where `rd_en` is high, when it loads the word at `rd_addr`. With `rd_en` low it holds its last value, even while `rd_addr` changes.
- R4: A masked write to a different address can be accepted on every consecutive clock edge, and every one of them takes effect.
- R5: Writes to the same address one or two edges apart merge in order. Each merge builds on the result of the earlier write, not on the stale array contents.
- R6: A write accepted at edge E0 commits at edge E0+2. A read registered at E0+1 or E0+2 returns the old word; a read registered at E0+3 or later returns the merged word.
- R7: A synchronous active-high `rst` sets `rd_data` to 0 and drops every write not yet committed. A write whose commit edge is the reset edge itself still lands. Array contents are not cleared.
- R8: `DATA_W` and `DEPTH` set the word width and the word count, and the address width is ceil(log2(`DEPTH`)). Every address from 0 to `DEPTH`-1 is usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of pipeline state and read output |
| wr_en | input | 1 | Accept a masked write on this edge |
| wr_addr | input | AW | Write address |
| wr_data | input | DATA_W | Write data |
| wr_mask | input | DATA_W | Per-bit write mask, 1 = take new bit |
| rd_en | input | 1 | Load read output on this edge |
| rd_addr | input | AW | Read address |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench works on an 8-bit by 16-word configuration and compares the block with a reference array that applies each merge at once. Writes to the reference reach a committed copy two edges later, and that copy is what the read port is compared against.

All 256 mask values are applied back to back to one address. This separates a correct per-bit merge and correct forwarding from the immediately preceding write from a design that merges against a stale word. Interleaved patterns (A, B, A) exercise forwarding from the write two edges back. Reads polled every cycle on an address being written pin the exact commit edge. Idle-enable cycles with toggling inputs, read-hold cycles with a moving address, and a reset that lands on writes in flight show that nothing leaks into the array or the output.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

   // Where the merge stage takes its old word from
   typedef enum logic [1:0] {
      SRC_ARRAY   = 2'd0,
      SRC_STAGE2  = 2'd1,
      SRC_RETIRED = 2'd2
   } src_sel_e;

   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/bmr_store.sv
module bmr_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned AW     = bmr_pkg::addr_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cw_en,
   input  logic [AW-1:0]     cw_addr,
   input  logic [DATA_W-1:0] cw_word,
   input  logic              ra_en,
   input  logic [AW-1:0]     ra_addr,
   output logic [DATA_W-1:0] ra_q,
   input  logic              rb_en,
   input  logic [AW-1:0]     rb_addr,
   output logic [DATA_W-1:0] rb_q
);
   localparam bit POW2 = (DEPTH == (32'd1 << AW));

   logic [DATA_W-1:0] mem [DEPTH];
   logic              cw_ok, ra_ok, rb_ok;

   generate
      if (POW2) begin : g_full
         assign cw_ok = 1'b1;
         assign ra_ok = 1'b1;
         assign rb_ok = 1'b1;
      end else begin : g_part
         assign cw_ok = ({{(32-AW){1'b0}}, cw_addr} < DEPTH);
         assign ra_ok = ({{(32-AW){1'b0}}, ra_addr} < DEPTH);
         assign rb_ok = ({{(32-AW){1'b0}}, rb_addr} < DEPTH);
      end
   endgenerate

   // Whole-word write, read-before-write on the internal port
   always_ff @(posedge clk) begin
      if (cw_en && cw_ok) mem[cw_addr] <= cw_word;
      if (ra_en) ra_q <= ra_ok ? mem[ra_addr] : '0;
   end

   always_ff @(posedge clk) begin
      if (rst)        rb_q <= '0;
      else if (rb_en) rb_q <= rb_ok ? mem[rb_addr] : '0;
   end

endmodule

// File: rtl/bmr_hazard.sv
module bmr_hazard #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned AW     = 9
) (
   input  logic [AW-1:0]     cur_addr,
   input  logic              s2_v,
   input  logic [AW-1:0]     s2_addr,
   input  logic [DATA_W-1:0] s2_word,
   input  logic              s3_v,
   input  logic [AW-1:0]     s3_addr,
   input  logic [DATA_W-1:0] s3_word,
   input  logic [DATA_W-1:0] arr_word,
   output bmr_pkg::src_sel_e sel,
   output logic [DATA_W-1:0] base_word
);
   import bmr_pkg::*;

   // Newest pending write wins
   always_comb begin
      if (s2_v && (s2_addr == cur_addr))      sel = SRC_STAGE2;
      else if (s3_v && (s3_addr == cur_addr)) sel = SRC_RETIRED;
      else                                     sel = SRC_ARRAY;
   end

   always_comb begin
      unique case (sel)
         SRC_STAGE2:  base_word = s2_word;
         SRC_RETIRED: base_word = s3_word;
         default:     base_word = arr_word;
      endcase
   end

endmodule

// File: rtl/bmr_merge.sv
module bmr_merge #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   input  logic [DATA_W-1:0] sel_new,
   output logic [DATA_W-1:0] out_word
);
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign out_word[b] = sel_new[b] ? new_word[b] : old_word[b];
      end
   endgenerate
endmodule

// File: rtl/bitmask_rmw_ram.sv
module bitmask_rmw_ram #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned AW     = bmr_pkg::addr_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   import bmr_pkg::*;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("bitmask_rmw_ram: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("bitmask_rmw_ram: DEPTH must be at least 2");
      end
      if (AW != addr_bits(DEPTH)) begin : g_bad_aw
         $error("bitmask_rmw_ram: AW must be ceil(log2(DEPTH))");
      end
   endgenerate

   // Stage 1: accepted write, array read in flight
   logic              s1_valid;
   logic [AW-1:0]     s1_addr;
   logic [DATA_W-1:0] s1_data, s1_mask;
   // Stage 2: merged word, commits on next edge
   logic              s2_valid;
   logic [AW-1:0]     s2_addr;
   logic [DATA_W-1:0] s2_word;
   // Stage 3: word committed on the last edge (invisible to the array read)
   logic              s3_valid;
   logic [AW-1:0]     s3_addr;
   logic [DATA_W-1:0] s3_word;

   logic [DATA_W-1:0] arr_old, base_word, merged;
   src_sel_e          src_sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s2_valid <= 1'b0;
         s3_valid <= 1'b0;
      end else begin
         s1_valid <= wr_en;
         s2_valid <= s1_valid;
         s3_valid <= s2_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         s1_addr <= wr_addr;
         s1_data <= wr_data;
         s1_mask <= wr_mask;
      end
      s2_addr <= s1_addr;
      s2_word <= merged;
      s3_addr <= s2_addr;
      s3_word <= s2_word;
   end

   bmr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk     (clk),
      .rst     (rst),
      .cw_en   (s2_valid),
      .cw_addr (s2_addr),
      .cw_word (s2_word),
      .ra_en   (wr_en),
      .ra_addr (wr_addr),
      .ra_q    (arr_old),
      .rb_en   (rd_en),
      .rb_addr (rd_addr),
      .rb_q    (rd_data)
   );

   bmr_hazard #(.DATA_W(DATA_W), .AW(AW)) u_hazard (
      .cur_addr  (s1_addr),
      .s2_v      (s2_valid),
      .s2_addr   (s2_addr),
      .s2_word   (s2_word),
      .s3_v      (s3_valid),
      .s3_addr   (s3_addr),
      .s3_word   (s3_word),
      .arr_word  (arr_old),
      .sel       (src_sel),
      .base_word (base_word)
   );

   bmr_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word (base_word),
      .new_word (s1_data),
      .sel_new  (s1_mask),
      .out_word (merged)
   );

endmodule

// File: rtl/bmr_checker.sv
module bmr_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned AW     = 9
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              s1_valid,
   input logic [AW-1:0]     s1_addr,
   input logic [DATA_W-1:0] s1_data,
   input logic [DATA_W-1:0] s1_mask,
   input logic              s2_valid,
   input logic [AW-1:0]     s2_addr,
   input logic [DATA_W-1:0] s2_word
);
   // R3
   rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));

   // R7
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (rd_data == '0) && !s1_valid && !s2_valid);

   // R2
   idle_write_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> !s1_valid);

   // R6
   accept_stage_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> s1_valid);

   // R6
   commit_stage_chk: assert property (@(posedge clk) disable iff (rst)
      s1_valid |=> s2_valid && (s2_addr == $past(s1_addr)));

   // R5
   fwd_chain_chk: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s2_valid && (s1_addr == s2_addr)) |=>
         (s2_word == (($past(s2_word) & ~$past(s1_mask)) |
                      ($past(s1_data) & $past(s1_mask)))));
endmodule

bind bitmask_rmw_ram bmr_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .rd_data  (rd_data),
   .s1_valid (s1_valid),
   .s1_addr  (s1_addr),
   .s1_data  (s1_data),
   .s1_mask  (s1_mask),
   .s2_valid (s2_valid),
   .s2_addr  (s2_addr),
   .s2_word  (s2_word)
);

// File: tb/sim_bitmask_rmw_ram.sv
`timescale 1ns/1ps
module sim_bitmask_rmw_ram;
   localparam int DW = 8;
   localparam int DP = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0, wr_mask = '0;
   logic [DW-1:0] rd_data;

   int    total = 0;
   int    bad   = 0;
   string tag   = "R7";

   always #2 clk = ~clk;

   bitmask_rmw_ram #(.DATA_W(DW), .DEPTH(DP)) u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_mask(wr_mask), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // Reference: logical array merges at once, committed copy two edges later
   logic [DW-1:0] logical [DP];
   logic [DW-1:0] cmt     [DP];
   logic [DW-1:0] dexp = '0;
   logic          pv1 = 1'b0, pv2 = 1'b0;
   logic [AW-1:0] pa1, pa2;
   logic [DW-1:0] pw1, pw2;

   always @(posedge clk) begin
      if (rst)        dexp = '0;
      else if (rd_en) dexp = cmt[rd_addr];
      if (pv2) cmt[pa2] = pw2;
      if (rst) begin
         pv1 = 1'b0;
         pv2 = 1'b0;
         for (int i = 0; i < DP; i++) logical[i] = cmt[i];
      end else begin
         pv2 = pv1; pa2 = pa1; pw2 = pw1;
         pv1 = 1'b0;
         if (wr_en) begin
            logical[wr_addr] = (logical[wr_addr] & ~wr_mask) | (wr_data & wr_mask);
            pv1 = 1'b1; pa1 = wr_addr; pw1 = logical[wr_addr];
         end
      end
   end

   task automatic check(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: got %h want %h", tag, what, act, exp);
      end
   endtask

   // One cycle: inputs are already set at a negedge; check at the next one
   task automatic cyc();
      @(negedge clk);
      check("rd_data", rd_data, dexp);
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d, input logic [DW-1:0] m);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_mask = m;
   endtask

   task automatic idle();
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic read_all();
      wr_en = 1'b0;
      for (int a = 0; a < DP; a++) begin
         rd_en = 1'b1; rd_addr = AW'(a);
         cyc();
      end
      rd_en = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      cyc();
      rst = 1'b0;
      // R7: output reads 0 after reset
      tag = "R7"; cyc();
      check("reset value", rd_data, '0);

      // R4: full-mask write every cycle to every address
      tag = "R4";
      for (int a = 0; a < DP; a++) begin wr(a, DW'(a * 17 + 3), '1); cyc(); end
      idle(); cyc(); cyc(); cyc();
      read_all();

      // R1 / R5: every mask value back to back on one address
      tag = "R1";
      for (int i = 0; i < 256; i++) begin wr(5, DW'(i * 29 + 7), DW'(i)); cyc(); end
      idle(); cyc(); cyc(); cyc();
      rd_en = 1'b1; rd_addr = 4'd5; cyc(); rd_en = 1'b0;
      check("R1 final word", rd_data, logical[5]);

      // R5: same address two edges apart (A, B, A pattern)
      tag = "R5";
      for (int i = 0; i < 24; i++) begin
         wr(((i % 2) == 0) ? 9 : 10, DW'(i * 53 + 1), DW'(i * 91 + 13)); cyc();
      end
      for (int i = 0; i < 18; i++) begin
         wr(((i % 3) == 1) ? 11 : 12, DW'(i * 37 + 2), DW'(i * 71 + 5)); cyc();
      end
      idle(); cyc(); cyc(); cyc();
      read_all();

      // R6: poll the written address each cycle, old data until commit is seen
      tag = "R6";
      rd_en = 1'b1; rd_addr = 4'd2;
      wr(2, 8'hA5, 8'h0F); cyc();
      wr_en = 1'b0; cyc();
      check("R6 edge+1 old", rd_data, cmt[2]);
      cyc();
      cyc();
      check("R6 edge+3 new", rd_data, logical[2]);
      for (int i = 0; i < 20; i++) begin wr(2, DW'(i * 13), DW'(i * 45 + 3)); cyc(); end
      idle(); cyc(); cyc(); cyc();

      // R2: inputs toggle but enable low
      tag = "R2";
      for (int i = 0; i < 16; i++) begin
         wr_en = 1'b0; wr_addr = AW'(i); wr_data = DW'(~i); wr_mask = '1; cyc();
      end
      read_all();

      // R3: read address moves with enable low, output must hold
      tag = "R3";
      rd_en = 1'b1; rd_addr = 4'd3; cyc();
      rd_en = 1'b0;
      for (int i = 0; i < 8; i++) begin
         rd_addr = AW'(i + 6); cyc();
         check("R3 hold", rd_data, cmt[3]);
      end

      // R7: reset while writes in flight drops them, array keeps data
      tag = "R7";
      wr(4, 8'h3C, 8'hFF); cyc();
      wr(6, 8'hC3, 8'hFF); cyc();
      idle(); rst = 1'b1; cyc();
      check("R7 reset output", rd_data, '0);
      rst = 1'b0;
      read_all();

      // R8: top and bottom addresses of the range
      tag = "R8";
      wr(DP - 1, 8'h5A, 8'hF0); cyc();
      wr(0, 8'h81, 8'h18); cyc();
      idle(); cyc(); cyc(); cyc();
      rd_en = 1'b1; rd_addr = AW'(DP - 1); cyc();
      check("R8 top address", rd_data, logical[DP-1]);
      rd_addr = '0; cyc();
      check("R8 bottom address", rd_data, logical[0]);
      rd_en = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      bad++;
      $display("FAIL watchdog: got timeout want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule